// File: doc/BRIEF.md
# Intra-Group Store-Load Overlap Detector

This block watches the stores issued inside one dispatch group and flags any load in the same group that may read bytes one of those stores wrote. Each store issued in the group is written into a small table. The table holds the access size and two address operands: an offset term, which is either a register tag or a constant, and a base register tag. When a load is presented, the block compares it in the same cycle against every recorded store. If any store may overlap the load, it raises a no-op request. The scheduler then inserts a no-op instead of stalling.

A load matches a store in three ways. The first is when the operand pair is equal. The second is when the pair is equal with its two terms swapped. The third is when the bases are equal and both offsets are constants whose byte ranges intersect. The table is emptied when the group ends. Instruction decode and the choice of group boundaries are made outside the block.

Top module: `grp_overlap_det`

## Requirements
- R1: After a synchronous active-high reset the table is empty, `noop_req` is 0 and `ovf_flag` is 0.
- R2: A load whose offset operand (const flag and tag) and base tag both equal those of a recorded store raises `noop_req` in the same cycle.
- R3: When both offsets are register operands (const flag 0), a load whose offset tag equals a store's base tag and whose base tag equals that store's offset tag raises `noop_req`.
- R4: With equal base tags and both offsets constant, and the store offset below the load offset, `noop_req` rises exactly when store offset plus store size exceeds the load offset.
- R5: With equal base tags, both offsets constant, and the load offset at or below the store offset, `noop_req` rises exactly when load offset plus load size exceeds the store offset.
- R6: Size codes encode the access size: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes, 3 means 8 bytes and 4 means 16 bytes. Codes 5 to 7 are taken as 16 bytes.
- R7: `noop_req` is 0 whenever `ld_valid` is 0 or the table is empty.
- R8: `grp_clear` empties the table at the next edge. A store presented in the same cycle becomes the only entry of the new group.
- R9: The table holds 5 stores. A store presented while the table is full is dropped, and `ovf_flag` is set and stays set until reset.
- R10: Offset sums are formed 17 bits wide, so a range ending past 0xFFFF does not wrap around to low offsets.
- R11: Constant-offset loads and stores with different base tags do not match unless R2 or R3 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_clear | input | 1 | End of dispatch group; empties the table |
| st_valid | input | 1 | Record a store this cycle |
| st_size | input | 3 | Store size code |
| st_off_const | input | 1 | Store offset is a constant |
| st_off_tag | input | 16 | Store offset tag or constant value |
| st_base_tag | input | 16 | Store base register tag |
| ld_valid | input | 1 | Load query is present |
| ld_size | input | 3 | Load size code |
| ld_off_const | input | 1 | Load offset is a constant |
| ld_off_tag | input | 16 | Load offset tag or constant value |
| ld_base_tag | input | 16 | Load base register tag |
| noop_req | output | 1 | Load overlaps a recorded store; insert a no-op |
| ovf_flag | output | 1 | Sticky flag: a store was dropped on a full table |

## Verification
The assertions assume that reset is held for at least one edge before any strobe and that inputs are stable around the clock edge. They do not assume that the inputs are otherwise legal. Size codes above 4 and simultaneous clear and store are both defined behaviour. The stimulus changes inputs only on the falling edge and covers these cases directly. It includes a size code of 7, a clear issued together with a store, and a sixth store into a full table.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int TAG_W = 16;
    localparam int SZ_W  = 3;
    localparam int DEPTH = 5;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SUM_W = TAG_W + 1;

    typedef struct packed {
        logic             is_const;
        logic [TAG_W-1:0] tag;
    } operand_t;

    typedef struct packed {
        logic [SZ_W-1:0]  size;
        operand_t         off;
        logic [TAG_W-1:0] base;
    } access_t;

    function automatic logic [SUM_W-1:0] size_bytes(input logic [SZ_W-1:0] code);
        logic [SUM_W-1:0] n;
        if (code > SZ_W'(4))
            n = SUM_W'(16);
        else
            n = SUM_W'(1) << code;
        return n;
    endfunction

    function automatic operand_t as_reg(input logic [TAG_W-1:0] t);
        operand_t o;
        o.is_const = 1'b0;
        o.tag      = t;
        return o;
    endfunction

endpackage

// File: rtl/grp_store_table.sv
module grp_store_table
    import ovl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             wr_en,
    input  access_t          wr_data,
    output access_t          entries [DEPTH],
    output logic [DEPTH-1:0] valid,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    logic [CNT_W-1:0] base_cnt;
    logic             room;

    assign base_cnt = clear ? '0 : count;
    assign room     = (base_cnt < CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (wr_en && room)
                count <= base_cnt + CNT_W'(1);
            else
                count <= base_cnt;
            if (wr_en && !room)
                ovf <= 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && room && base_cnt == CNT_W'(i))
                entries[i] <= wr_data;
        end
        assign valid[i] = (CNT_W'(i) < count);
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_sticky_ovf_r9: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    p_clear_empties_r8: assert property (@(posedge clk) disable iff (rst)
        (clear && !wr_en) |=> (count == '0));

    p_clear_with_store_r8: assert property (@(posedge clk) disable iff (rst)
        (clear && wr_en) |=> (count == CNT_W'(1)));

    p_append_r9: assert property (@(posedge clk) disable iff (rst)
        (!clear && wr_en && count < CNT_W'(DEPTH)) |=> (count == $past(count) + CNT_W'(1)));

endmodule

// File: rtl/grp_match_entry.sv
module grp_match_entry
    import ovl_pkg::*;
(
    input  logic    live,
    input  access_t st,
    input  access_t ld,
    output logic    hit
);

    logic             same_pair;
    logic             swapped_pair;
    logic             range_ok;
    logic             range_hit;
    logic [SUM_W-1:0] st_lo;
    logic [SUM_W-1:0] ld_lo;
    logic [SUM_W-1:0] st_end;
    logic [SUM_W-1:0] ld_end;

    assign same_pair    = (ld.off == st.off) && (ld.base == st.base);
    assign swapped_pair = (ld.off == as_reg(st.base)) && (as_reg(ld.base) == st.off);

    assign st_lo  = {1'b0, st.off.tag};
    assign ld_lo  = {1'b0, ld.off.tag};
    assign st_end = st_lo + size_bytes(st.size);
    assign ld_end = ld_lo + size_bytes(ld.size);

    assign range_ok = (ld.base == st.base) && ld.off.is_const && st.off.is_const;

    always_comb begin
        if (st_lo < ld_lo)
            range_hit = (st_end > ld_lo);
        else
            range_hit = (ld_end > st_lo);
    end

    assign hit = live && (same_pair || swapped_pair || (range_ok && range_hit));

endmodule

// File: rtl/grp_overlap_det.sv
module grp_overlap_det
    import ovl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             grp_clear,
    input  logic             st_valid,
    input  logic [SZ_W-1:0]  st_size,
    input  logic             st_off_const,
    input  logic [TAG_W-1:0] st_off_tag,
    input  logic [TAG_W-1:0] st_base_tag,
    input  logic             ld_valid,
    input  logic [SZ_W-1:0]  ld_size,
    input  logic             ld_off_const,
    input  logic [TAG_W-1:0] ld_off_tag,
    input  logic [TAG_W-1:0] ld_base_tag,
    output logic             noop_req,
    output logic             ovf_flag
);

    access_t          st_acc;
    access_t          ld_acc;
    access_t          table_q [DEPTH];
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] hits;
    logic [CNT_W-1:0] fill;

    assign st_acc.size         = st_size;
    assign st_acc.off.is_const = st_off_const;
    assign st_acc.off.tag      = st_off_tag;
    assign st_acc.base         = st_base_tag;

    assign ld_acc.size         = ld_size;
    assign ld_acc.off.is_const = ld_off_const;
    assign ld_acc.off.tag      = ld_off_tag;
    assign ld_acc.base         = ld_base_tag;

    grp_store_table u_table (
        .clk     (clk),
        .rst     (rst),
        .clear   (grp_clear),
        .wr_en   (st_valid),
        .wr_data (st_acc),
        .entries (table_q),
        .valid   (live),
        .count   (fill),
        .ovf     (ovf_flag)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        grp_match_entry u_cmp (
            .live (live[i]),
            .st   (table_q[i]),
            .ld   (ld_acc),
            .hit  (hits[i])
        );
    end

    assign noop_req = ld_valid && (fill != '0) && (|hits);

    p_empty_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (fill == '0) |-> !noop_req);

    p_no_query_r7: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |-> !noop_req);

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (!ovf_flag && fill == '0));

    p_hits_in_fill_r9: assert property (@(posedge clk) disable iff (rst)
        $countones(hits) <= int'(fill));

endmodule

// File: tb/tb_grp_overlap_det.sv
`timescale 1ns/1ps
module tb_grp_overlap_det;

    logic        clk = 1'b0;
    logic        rst;
    logic        grp_clear;
    logic        st_valid;
    logic [2:0]  st_size;
    logic        st_off_const;
    logic [15:0] st_off_tag;
    logic [15:0] st_base_tag;
    logic        ld_valid;
    logic [2:0]  ld_size;
    logic        ld_off_const;
    logic [15:0] ld_off_tag;
    logic [15:0] ld_base_tag;
    logic        noop_req;
    logic        ovf_flag;

    always #2.5 clk = ~clk;

    grp_overlap_det dut (.*);

    typedef struct { int sz; bit oc; int ot; int bs; } rec_t;
    rec_t q[$];
    bit   ovf_m;
    int   n_tests = 0;
    int   n_fail  = 0;

    function automatic int bytes_of(int code);
        return (code > 4) ? 16 : (1 << code);
    endfunction

    function automatic bit model_hit();
        rec_t l;
        bit   h = 0;
        if (!ld_valid) return 0;
        l.sz = bytes_of(int'(ld_size)); l.oc = ld_off_const;
        l.ot = int'(ld_off_tag); l.bs = int'(ld_base_tag);
        foreach (q[i]) begin
            if (l.oc == q[i].oc && l.ot == q[i].ot && l.bs == q[i].bs) h = 1;
            if (!l.oc && !q[i].oc && l.ot == q[i].bs && l.bs == q[i].ot) h = 1;
            if (l.bs == q[i].bs && l.oc && q[i].oc) begin
                if (q[i].ot < l.ot) begin
                    if (q[i].ot + q[i].sz > l.ot) h = 1;
                end else begin
                    if (l.ot + l.sz > q[i].ot) h = 1;
                end
            end
        end
        return h;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // inputs are already set (after a falling edge); compare, then take one edge
    task automatic step(string req);
        rec_t r;
        #1;
        check(req, "noop_req", int'(noop_req), int'(model_hit()));
        check(req, "ovf_flag", int'(ovf_flag), int'(ovf_m));
        @(posedge clk);
        if (grp_clear) q.delete();
        if (st_valid) begin
            if (q.size() < 5) begin
                r.sz = bytes_of(int'(st_size)); r.oc = st_off_const;
                r.ot = int'(st_off_tag); r.bs = int'(st_base_tag);
                q.push_back(r);
            end else ovf_m = 1;
        end
        @(negedge clk);
        grp_clear = 0; st_valid = 0; ld_valid = 0;
    endtask

    task automatic put_st(int code, bit oc, int ot, int bs);
        st_valid = 1; st_size = 3'(code); st_off_const = oc;
        st_off_tag = 16'(ot); st_base_tag = 16'(bs);
    endtask

    task automatic put_ld(int code, bit oc, int ot, int bs);
        ld_valid = 1; ld_size = 3'(code); ld_off_const = oc;
        ld_off_tag = 16'(ot); ld_base_tag = 16'(bs);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1; grp_clear = 0; st_valid = 0; ld_valid = 0;
        st_size = 0; st_off_const = 0; st_off_tag = 0; st_base_tag = 0;
        ld_size = 0; ld_off_const = 0; ld_off_tag = 0; ld_base_tag = 0;
        ovf_m = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        put_ld(2, 0, 3, 7);               step("R1");   // empty after reset
        put_st(2, 0, 3, 7);               step("R7");   // record reg pair
        put_ld(2, 0, 3, 7);               step("R2");   // exact pair
        put_ld(0, 0, 7, 3);               step("R3");   // swapped pair
        put_ld(2, 0, 3, 8);               step("R2");   // base differs
        ld_valid = 0; ld_off_tag = 3; ld_base_tag = 7; step("R7");
        grp_clear = 1;                    step("R8");
        put_ld(2, 0, 3, 7);               step("R8");   // gone after clear

        put_st(3, 1, 8, 1);               step("R4");   // const 8, 8 bytes
        put_ld(0, 1, 12, 1);              step("R4");   // inside
        put_ld(0, 1, 16, 1);              step("R4");   // just past end
        put_ld(2, 1, 4, 1);               step("R5");   // 4+4 = 8, miss
        put_ld(3, 1, 4, 1);               step("R5");   // 4+8 > 8, hit
        put_ld(0, 1, 12, 2);              step("R11");  // other base
        put_st(4, 1, 16'hFFF8, 2);        step("R6");
        put_ld(0, 1, 0, 2);               step("R10");  // no wrap
        put_ld(0, 1, 16'hFFFF, 2);        step("R10");
        put_st(7, 1, 16'h100, 5);         step("R6");   // code 7 -> 16
        put_ld(0, 1, 16'h10F, 5);         step("R6");
        put_ld(0, 1, 16'h110, 5);         step("R6");

        grp_clear = 1; put_st(1, 0, 20, 21); step("R8"); // clear + store
        put_ld(3, 1, 8, 1);               step("R8");    // old entry gone
        put_ld(1, 0, 20, 21);             step("R8");    // new one kept
        for (int i = 0; i < 4; i++) begin
            put_st(0, 0, 30 + i, 40); step("R9");
        end
        put_st(0, 0, 99, 98);             step("R9");    // sixth: dropped
        put_ld(0, 0, 99, 98);             step("R9");
        put_ld(0, 0, 33, 40);             step("R9");
        grp_clear = 1;                    step("R9");
        put_ld(0, 0, 33, 40);             step("R9");    // sticky flag

        rst = 1; @(posedge clk); @(negedge clk); rst = 0;
        q.delete(); ovf_m = 0;
        put_ld(0, 0, 33, 40);             step("R1");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule